// File: doc/BRIEF.md
# Synchronous Burst Memory Frontend

This block is the device-side control logic of a pseudo-static memory that works either asynchronously or in synchronous burst mode. It watches the chip-enable, address-valid, output-enable and write-enable pins. Depending on the mode, it either passes address and strobes straight through to a small storage array, or it runs a burst with a fixed latency. A burst starts on an address-valid pulse, counts a configured number of clocks, and then steps through a linear, wrapping or unbounded sequence of beats.

The block drives a wait indicator and a separate enable for it, so the pad can be driven or left floating. It also produces the internal address, read strobe, write strobe and data-bus drive enable for the array. The host can hold off any beat by raising output-enable (for a read) or write-enable (for a write). Taking chip enable away ends the burst immediately.

Top module: `sbm_frontend`

## Requirements
- R1: The address is taken from `addr_i` only at clock edges where `ce_ni` and `adv_ni` are both low. A low `adv_ni` while `ce_ni` is high is ignored: it neither starts a burst nor changes the latched address. Address inputs presented while `adv_ni` is high have no effect.
- R2: In synchronous mode, the capture edge is the first rising clock edge that sees `adv_ni` high with `ce_ni` low, after an edge that saw both low. If `we_ni` is high at the capture edge, the burst is a read. Its first read beat (`mem_rd_o` high) occurs in the cycle after the `rd_lat_i`-th rising edge following the capture edge (`rd_lat_i` from 2 to 7).
- R3: If `we_ni` is low at the capture edge, the burst is a write. Its first write beat (`mem_wr_o` high) occurs after `rd_lat_i`-1 edges.
- R4: During a read burst, `wait_o` is low while the latency runs. It is high in the cycle just before the first beat. Once it is driven high, it stays high until the burst ends.
- R5: `wait_oe_o` turns on once the burst's own strobe (`oe_ni` for a read, `we_ni` for a write) is low during a burst. For a write, `wait_o` is high whenever it is driven.
- R6: In the burst phase, a high strobe suspends the beat. There is no array access, the address holds, and `wait_o` keeps its previous driven level.
- R7: If the beat being suspended is the final beat of a fixed-length burst, `wait_oe_o` is low.
- R8: `burst_len_i` sets the burst length as 0 = 4, 1 = 8, 2 = 16 and 3 = continuous. For a fixed length, the address advances by one per beat and wraps within the aligned block of that length. After the last beat the block returns to idle, with no strobes and `wait_oe_o` low.
- R9: In continuous mode, the address advances linearly across block boundaries until chip enable is removed.
- R10: `ce_ni` high ends any burst at once. Strobes, `dq_oe_o` and `wait_oe_o` drop in that cycle, and no beat resumes afterwards.
- R11: In asynchronous mode (`sync_mode_i` = 0), `wait_oe_o` stays low. `mem_addr_o` follows `addr_i` while `adv_ni` is low and keeps the last latched value while it is high. `mem_rd_o` is `!ce_ni & !oe_ni & we_ni`, and `mem_wr_o` is `!ce_ni & !we_ni`.
- R12: `dq_oe_o` is high exactly when a read access is in progress, and never together with a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 = synchronous burst, 0 = asynchronous |
| rd_lat_i | input | LAT_W | Read latency in clocks |
| burst_len_i | input | 2 | Burst length code |
| ce_ni | input | 1 | Chip enable, active low |
| adv_ni | input | 1 | Address valid, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Address pins |
| wait_o | output | 1 | Wait level (low = next data invalid) |
| wait_oe_o | output | 1 | Drive enable for the wait pad |
| mem_addr_o | output | ADDR_W | Array address |
| mem_rd_o | output | 1 | Array read strobe |
| mem_wr_o | output | 1 | Array write strobe |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
Several properties are checked on every cycle:
- chip-enable removal forces idle on the next edge;
- the latency counter always hands over to the burst phase;
- the beat counter never passes the last beat;
- fixed-length bursts never carry out of their aligned block;
- the wait level never falls while driven;
- the wait pad floats in asynchronous mode;
- read and write strobes never overlap.

Only the directed scenarios can show the rest. These are the exact cycle of the first read and write beat for each latency, the wrap order of the addresses, and the held level and floating pad during a suspend. They also cover the lack of resumption after termination and the pass-through timing of asynchronous mode.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LAT = 2'd1, ST_BURST = 2'd2} st_e;
  typedef enum logic [1:0] {BL_4 = 2'd0, BL_8 = 2'd1, BL_16 = 2'd2, BL_CONT = 2'd3} bl_e;

  localparam int unsigned BEAT_W = 4;

  function automatic logic [BEAT_W-1:0] bl_last(input bl_e bl);
    case (bl)
      BL_4:    return 4'd3;
      BL_8:    return 4'd7;
      default: return 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/sbm_ctrl.sv
module sbm_ctrl import sbm_pkg::*; #(
  parameter int unsigned LAT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [LAT_W-1:0] rd_lat_i,
  input  bl_e              blen_i,
  input  logic             ce_ni,
  input  logic             adv_ni,
  input  logic             oe_ni,
  input  logic             we_ni,
  output st_e              state_o,
  output logic             dir_wr_o,
  output bl_e              blen_o,
  output logic             start_o,
  output logic             beat_o,
  output logic             last_o,
  output logic             lat_one_o,
  output logic             strobe_low_o
);
  st_e               state_q;
  logic              adv_low_q, dir_wr_q;
  logic [LAT_W-1:0]  lat_q;
  logic [BEAT_W-1:0] cnt_q;
  bl_e               blen_q;

  logic start, beat, last, strobe_low;

  assign start      = sync_i & ~ce_ni & adv_ni & adv_low_q & (state_q == ST_IDLE);
  assign strobe_low = dir_wr_q ? ~we_ni : ~oe_ni;
  assign beat       = sync_i & ~ce_ni & strobe_low & (state_q == ST_BURST);
  assign last       = (blen_q != BL_CONT) & (cnt_q == bl_last(blen_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      adv_low_q <= 1'b0;
      dir_wr_q  <= 1'b0;
      lat_q     <= '0;
      cnt_q     <= '0;
      blen_q    <= BL_4;
    end else begin
      adv_low_q <= sync_i & ~ce_ni & ~adv_ni;
      if (ce_ni) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (start) begin
            state_q  <= ST_LAT;
            dir_wr_q <= ~we_ni;
            blen_q   <= blen_i;
            lat_q    <= we_ni ? rd_lat_i : rd_lat_i - 1'b1;
          end
          ST_LAT: begin
            if (lat_q <= LAT_W'(1)) begin
              state_q <= ST_BURST;
              cnt_q   <= '0;
            end else begin
              lat_q <= lat_q - 1'b1;
            end
          end
          ST_BURST: if (beat) begin
            if (last) state_q <= ST_IDLE;
            else      cnt_q   <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o      = state_q;
  assign dir_wr_o     = dir_wr_q;
  assign blen_o       = blen_q;
  assign start_o      = start;
  assign beat_o       = beat;
  assign last_o       = last;
  assign lat_one_o    = (state_q == ST_LAT) & (lat_q == LAT_W'(1));
  assign strobe_low_o = strobe_low;

  assert_ce_term_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (state_q == ST_IDLE));

  assert_lat_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && state_q == ST_LAT && lat_q == LAT_W'(1)) |=> (state_q == ST_BURST));

  assert_beat_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST && blen_q != BL_CONT) |-> (cnt_q <= bl_last(blen_q)));
endmodule

// File: rtl/sbm_addr.sv
module sbm_addr import sbm_pkg::*; #(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              start_i,
  input  logic              beat_i,
  input  bl_e               blen_i,
  output logic [ADDR_W-1:0] mem_addr_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] lat_addr_q, cur_q, msk, nxt;

  assign msk = {{HI_W{1'b0}}, bl_last(blen_i)};
  // fixed lengths wrap inside the aligned block, continuous runs on
  assign nxt = (blen_i == BL_CONT) ? cur_q + 1'b1
                                   : (cur_q & ~msk) | ((cur_q + 1'b1) & msk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_q <= '0;
      cur_q      <= '0;
    end else begin
      if (!ce_ni && !adv_ni) lat_addr_q <= addr_i;
      if (start_i)           cur_q      <= lat_addr_q;
      else if (beat_i)       cur_q      <= nxt;
    end
  end

  assign mem_addr_o = sync_i ? cur_q : (adv_ni ? lat_addr_q : addr_i);

  assert_wrap_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && blen_i != BL_CONT) |=>
      (cur_q[ADDR_W-1:BEAT_W] == $past(cur_q[ADDR_W-1:BEAT_W])));
endmodule

// File: rtl/sbm_wait.sv
module sbm_wait import sbm_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic ce_ni,
  input  st_e  state_i,
  input  logic dir_wr_i,
  input  logic strobe_low_i,
  input  logic lat_one_i,
  input  logic last_i,
  output logic wait_o,
  output logic wait_oe_o
);
  logic en_q, hold_q;
  logic active, lvl, final_susp;

  assign active     = sync_i & ~ce_ni & (state_i != ST_IDLE);
  assign lvl        = dir_wr_i | (state_i == ST_BURST) | lat_one_i;
  assign final_susp = (state_i == ST_BURST) & last_i & ~strobe_low_i;
  assign wait_oe_o  = active & (strobe_low_i | en_q) & ~final_susp;
  // suspended beats repeat the last driven level
  assign wait_o     = wait_oe_o & (strobe_low_i ? lvl : hold_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      en_q   <= active & (en_q | strobe_low_i);
      hold_q <= active & wait_o;
    end
  end

  assert_wait_stays_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_oe_o && wait_o && !ce_ni && sync_i) |=> (!wait_oe_o || wait_o));

  assert_async_hiz_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |-> !wait_oe_o);
endmodule

// File: rtl/sbm_frontend.sv
module sbm_frontend import sbm_pkg::*; #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned LAT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic [LAT_W-1:0]  rd_lat_i,
  input  logic [1:0]        burst_len_i,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wait_o,
  output logic              wait_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              dq_oe_o
);
  st_e  state;
  bl_e  blen_q;
  logic dir_wr, start, beat, last, lat_one, strobe_low;

  sbm_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk_i, .rst_ni, .sync_i(sync_mode_i), .rd_lat_i,
    .blen_i(bl_e'(burst_len_i)), .ce_ni, .adv_ni, .oe_ni, .we_ni,
    .state_o(state), .dir_wr_o(dir_wr), .blen_o(blen_q), .start_o(start),
    .beat_o(beat), .last_o(last), .lat_one_o(lat_one), .strobe_low_o(strobe_low)
  );

  sbm_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .sync_i(sync_mode_i), .ce_ni, .adv_ni, .addr_i,
    .start_i(start), .beat_i(beat), .blen_i(blen_q), .mem_addr_o
  );

  sbm_wait u_wait (
    .clk_i, .rst_ni, .sync_i(sync_mode_i), .ce_ni, .state_i(state),
    .dir_wr_i(dir_wr), .strobe_low_i(strobe_low), .lat_one_i(lat_one),
    .last_i(last), .wait_o, .wait_oe_o
  );

  assign mem_rd_o = sync_mode_i ? (beat & ~dir_wr) : (~ce_ni & ~oe_ni & we_ni);
  assign mem_wr_o = sync_mode_i ? (beat &  dir_wr) : (~ce_ni & ~we_ni);
  assign dq_oe_o  = mem_rd_o;

  assert_rd_wr_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dq_oe_o && mem_wr_o));

  assert_term_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && sync_mode_i) |-> !(mem_rd_o || mem_wr_o || wait_oe_o));
endmodule

// File: tb/tb_sbm_frontend.sv
`timescale 1ns/1ps
module tb_sbm_frontend;
  localparam int ADDR_W = 22;
  localparam int LAT_W  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 1'b1;
  logic [LAT_W-1:0] rd_lat = 3'd2;
  logic [1:0] blen = 2'd0;
  logic ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic wait_w, wait_oe, mem_rd, mem_wr, dq_oe;
  logic [ADDR_W-1:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sbm_frontend #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .rd_lat_i(rd_lat),
    .burst_len_i(blen), .ce_ni(ce_n), .adv_ni(adv_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .wait_o(wait_w), .wait_oe_o(wait_oe), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .dq_oe_o(dq_oe)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic close_bus();
    step(); ce_n = 1; adv_n = 1; oe_n = 1; we_n = 1;
    step();
  endtask

  task automatic open_burst(input bit wr, input int rl, input logic [1:0] blc, input int a);
    rd_lat = LAT_W'(rl); blen = blc; sync_mode = 1;
    step(); ce_n = 0; adv_n = 0; addr = ADDR_W'(a); we_n = !wr; oe_n = 1;
    step(); adv_n = 1; addr = ~ADDR_W'(a); oe_n = wr;  // R1: ignored while adv high
  endtask

  task automatic t_reset();
    step(); #1;
    chk("R10 reset rd", mem_rd, 0);
    chk("R10 reset wr", mem_wr, 0);
    chk("R10 reset woe", wait_oe, 0);
    chk("R12 reset dq", dq_oe, 0);
  endtask

  task automatic t_burst(input bit wr, input int rl, input logic [1:0] blc, input int a);
    int n, lat, base;
    n = (blc == 0) ? 4 : (blc == 1) ? 8 : 16;
    lat = wr ? rl - 1 : rl;
    base = a & ~(n - 1);
    open_burst(wr, rl, blc, a);
    for (int j = 0; j < lat; j++) begin
      step(); #1;
      chk(wr ? "R3 no early wr" : "R2 no early rd", mem_rd | mem_wr, 0);
      chk("R5 wait_oe latency", wait_oe, 1);
      chk(wr ? "R5 wait write" : "R4 wait latency", wait_w, wr ? 1 : (j == lat - 1));
    end
    for (int b = 0; b < n; b++) begin
      step(); #1;
      if (wr) chk(b == 0 ? "R3 first wr" : "R8 wr beat", mem_wr, 1);
      else    chk(b == 0 ? "R2 first rd" : "R8 rd beat", mem_rd, 1);
      chk("R8 addr", mem_addr, base + (((a - base) + b) % n));
      chk("R12 dq", dq_oe, !wr);
      chk("R4 wait burst", {wait_oe, wait_w}, 2'b11);
    end
    step(); #1;
    chk("R8 end strobes", mem_rd | mem_wr, 0);
    chk("R8 end wait_oe", wait_oe, 0);
    close_bus();
  endtask

  task automatic t_rd_suspend();
    open_burst(0, 2, 2'd0, 'h40);
    step(); step();
    step(); #1; chk("R2 beat0", mem_rd, 1); chk("R6 a0", mem_addr, 'h40);
    step(); oe_n = 1; #1;
    chk("R6 susp rd", mem_rd, 0); chk("R12 susp dq", dq_oe, 0);
    chk("R6 susp addr", mem_addr, 'h41); chk("R6 susp wait", {wait_oe, wait_w}, 2'b11);
    step(); #1; chk("R6 susp hold addr", mem_addr, 'h41); chk("R6 hold wait", wait_w, 1);
    step(); oe_n = 0; #1; chk("R6 resume", mem_rd, 1); chk("R6 resume addr", mem_addr, 'h41);
    step(); #1; chk("R6 a2", mem_addr, 'h42);
    step(); oe_n = 1; #1;
    chk("R7 final susp hiz", wait_oe, 0); chk("R7 final no rd", mem_rd, 0);
    chk("R7 final addr", mem_addr, 'h43);
    step(); oe_n = 0; #1; chk("R7 final beat", mem_rd, 1); chk("R7 wait back", wait_oe, 1);
    step(); #1; chk("R8 idle after", mem_rd, 0); chk("R8 idle woe", wait_oe, 0);
    close_bus();
  endtask

  task automatic t_wr_suspend();
    open_burst(1, 3, 2'd0, 'h80);
    step(); step();
    step(); #1; chk("R3 wbeat0", mem_wr, 1); chk("R6 wa0", mem_addr, 'h80);
    step(); we_n = 1; #1;
    chk("R6 wsusp", mem_wr, 0); chk("R6 wsusp addr", mem_addr, 'h81);
    chk("R5 wsusp wait", {wait_oe, wait_w}, 2'b11);
    step(); we_n = 0; #1; chk("R6 wresume", mem_wr, 1); chk("R6 wresume addr", mem_addr, 'h81);
    step(); step(); #1; chk("R6 wa3", mem_addr, 'h83);
    step(); #1; chk("R8 widle", mem_wr, 0);
    close_bus();
  endtask

  task automatic t_ce_term();
    open_burst(0, 2, 2'd2, 'h100);
    step(); step();
    for (int b = 0; b < 3; b++) begin step(); #1; chk("R10 pre", mem_addr, 'h100 + b); end
    step(); ce_n = 1; #1;
    chk("R10 term rd", mem_rd, 0); chk("R10 term woe", wait_oe, 0); chk("R12 term dq", dq_oe, 0);
    step(); ce_n = 0; adv_n = 1; oe_n = 0;
    for (int k = 0; k < 4; k++) begin
      #1; chk("R10 no resume rd", mem_rd, 0); chk("R10 no resume woe", wait_oe, 0);
      step();
    end
    close_bus();
  endtask

  task automatic t_adv_masked();
    sync_mode = 1; rd_lat = 3'd2;
    step(); ce_n = 1; adv_n = 0; addr = 'h5;
    step(); ce_n = 0; adv_n = 1; oe_n = 0;
    for (int k = 0; k < 5; k++) begin
      step(); #1; chk("R1 masked adv rd", mem_rd, 0); chk("R1 masked adv woe", wait_oe, 0);
    end
    close_bus();
  endtask

  task automatic t_continuous();
    open_burst(0, 2, 2'd3, 'h0E);
    step(); step();
    for (int b = 0; b < 5; b++) begin
      step(); #1; chk("R9 cont rd", mem_rd, 1); chk("R9 cont addr", mem_addr, 'h0E + b);
    end
    close_bus();
  endtask

  task automatic t_async();
    sync_mode = 0;
    step(); ce_n = 0; adv_n = 0; addr = 'h55; oe_n = 0; we_n = 1; #1;
    chk("R11 flow addr", mem_addr, 'h55); chk("R11 rd", mem_rd, 1);
    chk("R12 async dq", dq_oe, 1); chk("R11 hiz", wait_oe, 0);
    step(); addr = 'h66; #1; chk("R11 flow addr2", mem_addr, 'h66);
    step(); adv_n = 1; addr = 'h77; oe_n = 1; we_n = 0; #1;
    chk("R1 latched", mem_addr, 'h66); chk("R11 wr", mem_wr, 1); chk("R11 no rd", mem_rd, 0);
    step(); ce_n = 1; adv_n = 0; addr = 'h12; we_n = 1; #1;
    chk("R11 ce off wr", mem_wr, 0);
    step(); ce_n = 0; adv_n = 1; #1;
    chk("R1 async masked", mem_addr, 'h66); chk("R11 hiz2", wait_oe, 0);
    close_bus();
    sync_mode = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_burst(0, 3, 2'd0, 'h6);
    t_burst(0, 4, 2'd1, 'h1D);
    t_burst(0, 2, 2'd2, 'h3B);
    t_burst(1, 3, 2'd0, 'h22);
    t_burst(1, 2, 2'd2, 'h35);
    t_burst(1, 7, 2'd1, 'h13);
    t_rd_suspend();
    t_wr_suspend();
    t_ce_term();
    t_adv_masked();
    t_continuous();
    t_async();
    summary();
  end
endmodule